// File: doc/BRIEF.md
# GPIO Bank with Per-Bit Masked Writes

This block holds the pin state for one bank of general-purpose I/O: four ports of eight pins each, 32 pins in all. A simple 32-bit register bus with single-cycle read and write strobes reaches eight register groups per port. They cover alternate-function selection, output enable, output value, synchronized input level, interrupt status, interrupt enable and interrupt type, plus a write-one-to-clear status register. The block drives the pad output and output-enable lines. Pad inputs are brought in through a two-flop synchronizer, and the synchronized levels are handed to an external per-pin event detector.

Every writable group also appears at an alias address. A write to an alias treats the upper byte of the data word as a per-pin write enable and the lower byte as the new pin values. Software can therefore change individual pins atomically, with no read-modify-write sequence, even when several agents share a port.

The event detector is a separate block. It reports pin events as one-cycle pulses on `irq_evt_i`. This bank latches those pulses into status and combines status with enable into one bank interrupt line.

Top module: `gpio_bank`

## Requirements
- R1: After reset every register is zero. All pads are released (`pad_oe_o` = 0, `pad_out_o` = 0), `irq_o` is 0 and `rdata_o` is 0.
- R2: Address decoding works as follows. Bits [3:2] select the port. Bits [6:4] select the group: 0 alternate-function select, 1 output enable, 2 output value, 3 input level, 4 interrupt status, 5 interrupt enable, 6 interrupt type, 7 status clear. Bit 11 selects the alias. A plain write stores `wdata_i[7:0]` and ignores the other data bits. A read returns the register in bits [7:0] with zeros above, on `rdata_o` in the cycle after `rd_i`.
- R3: Without a bus write, the configuration, output-enable, output, enable and type registers keep their values, so `pad_oe_o` and `pad_out_o` stay stable.
- R4: A write to an alias updates pin n to `wdata_i[n]` only where `wdata_i[8+n]` is 1. Pins whose enable bit is 0 keep their old value.
- R5: `pad_oe_o` equals the output-enable register. `pad_out_o` carries the output register bit where the pin is enabled and 0 where it is released.
- R6: `pin_sync_o` follows `pad_in_i` two clock edges later. The input group reads these synchronized levels, and writes to the input group are ignored.
- R7: A pulse on `irq_evt_i[k]` sets status bit k on the next edge. `irq_o` is high while any pin has both status and enable set.
- R8: Writing 1 to bit n of the clear group clears status bit n of that port, and writing 0 leaves it unchanged. An event on the same pin in the same cycle wins over the clear.
- R9: The following addresses read as zero and ignore writes: any address with bits [10:7] or [1:0] nonzero, and the aliases of the input and clear groups. Reads of the clear group and of all alias addresses also return zero.
- R10: `cfg_o`, `int_en_o` and `int_type_o` present their registers, and pin index k equals port*8 + bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_i | input | 1 | Write strobe, one cycle |
| rd_i | input | 1 | Read strobe, one cycle |
| addr_i | input | 12 | Byte address within the bank |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| pad_in_i | input | 32 | Raw pad levels |
| pad_out_o | output | 32 | Pad drive values |
| pad_oe_o | output | 32 | Pad drive enables |
| cfg_o | output | 32 | Per-pin GPIO/alternate-function select |
| int_en_o | output | 32 | Per-pin interrupt enables |
| int_type_o | output | 32 | Per-pin interrupt type bits for the detector |
| pin_sync_o | output | 32 | Synchronized pad levels for the detector |
| irq_evt_i | input | 32 | Per-pin event pulses from the detector |
| irq_o | output | 1 | Bank interrupt |

## Verification
The bench builds the bank with its default shape of four ports of eight pins, which makes the full two-bit port field and the top port (pins 24 to 31) reachable. With that shape, masked writes can touch pins at both ends of a byte. Status can be set and cleared on the top port, where a port-index slip would show up. Addresses with stray bits between the group field and the alias bit can also be probed to confirm that they decode as unmapped.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    typedef enum logic [2:0] {
        GRP_CFG = 3'd0,
        GRP_OE  = 3'd1,
        GRP_OUT = 3'd2,
        GRP_IN  = 3'd3,
        GRP_STS = 3'd4,
        GRP_EN  = 3'd5,
        GRP_TYP = 3'd6,
        GRP_CLR = 3'd7
    } grp_e;

    typedef struct packed {
        logic       in_bank;
        logic       alias_sel;
        grp_e       grp;
        logic [1:0] port;
    } dec_t;

    function automatic dec_t decode(logic [ADDR_W-1:0] a);
        dec_t d;
        d.in_bank   = (a[10:7] == 4'd0) && (a[1:0] == 2'd0);
        d.alias_sel = a[11];
        d.grp       = grp_e'(a[6:4]);
        d.port      = a[3:2];
        return d;
    endfunction

    function automatic logic writable(dec_t d);
        return d.in_bank && (d.grp != GRP_IN) &&
               !(d.alias_sel && d.grp == GRP_CLR);
    endfunction

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= d_i;
            stab_q <= meta_q;
        end
    end

    assign q_o = stab_q;
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_bank_pkg::*;
#(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          alias_sel,
    input  grp_e          grp,
    input  logic [2*PW-1:0] wdata,
    input  logic [PW-1:0] evt,
    output logic [PW-1:0] cfg,
    output logic [PW-1:0] oe,
    output logic [PW-1:0] out,
    output logic [PW-1:0] sts,
    output logic [PW-1:0] en,
    output logic [PW-1:0] typ
);
    typedef struct packed {
        logic [PW-1:0] cfg;
        logic [PW-1:0] oe;
        logic [PW-1:0] out;
        logic [PW-1:0] sts;
        logic [PW-1:0] en;
        logic [PW-1:0] typ;
    } port_regs_t;

    port_regs_t    r_q;
    logic [PW-1:0] mask;
    logic [PW-1:0] val;
    logic [PW-1:0] sts_nx;

    assign mask = alias_sel ? wdata[2*PW-1:PW] : '1;
    assign val  = wdata[PW-1:0];

    function automatic logic [PW-1:0] upd(logic [PW-1:0] old);
        return (old & ~mask) | (val & mask);
    endfunction

    always_comb begin
        sts_nx = r_q.sts;
        if (wr_en && grp == GRP_STS)
            sts_nx = upd(r_q.sts);
        else if (wr_en && grp == GRP_CLR)
            sts_nx = r_q.sts & ~val;
        sts_nx = sts_nx | evt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q.sts <= sts_nx;
            if (wr_en) begin
                case (grp)
                    GRP_CFG: r_q.cfg <= upd(r_q.cfg);
                    GRP_OE:  r_q.oe  <= upd(r_q.oe);
                    GRP_OUT: r_q.out <= upd(r_q.out);
                    GRP_EN:  r_q.en  <= upd(r_q.en);
                    GRP_TYP: r_q.typ <= upd(r_q.typ);
                    default: ;
                endcase
            end
        end
    end

    assign cfg = r_q.cfg;
    assign oe  = r_q.oe;
    assign out = r_q.out;
    assign sts = r_q.sts;
    assign en  = r_q.en;
    assign typ = r_q.typ;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int PORT_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_i,
    input  logic                     rd_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [DATA_W-1:0]        wdata_i,
    output logic [DATA_W-1:0]        rdata_o,
    input  logic [NPORTS*PORT_W-1:0] pad_in_i,
    output logic [NPORTS*PORT_W-1:0] pad_out_o,
    output logic [NPORTS*PORT_W-1:0] pad_oe_o,
    output logic [NPORTS*PORT_W-1:0] cfg_o,
    output logic [NPORTS*PORT_W-1:0] int_en_o,
    output logic [NPORTS*PORT_W-1:0] int_type_o,
    output logic [NPORTS*PORT_W-1:0] pin_sync_o,
    input  logic [NPORTS*PORT_W-1:0] irq_evt_i,
    output logic                     irq_o
);
    localparam int NPINS = NPORTS * PORT_W;

    dec_t              dec;
    logic              port_ok;
    logic              wr_ok;
    logic [NPINS-1:0]  sync_w;
    logic [NPINS-1:0]  oe_w, out_w, sts_w;
    logic [PORT_W-1:0] cfg_p [NPORTS];
    logic [PORT_W-1:0] oe_p  [NPORTS];
    logic [PORT_W-1:0] out_p [NPORTS];
    logic [PORT_W-1:0] sts_p [NPORTS];
    logic [PORT_W-1:0] en_p  [NPORTS];
    logic [PORT_W-1:0] typ_p [NPORTS];
    logic [DATA_W-1:0] rd_val;

    assign dec     = decode(addr_i);
    assign port_ok = int'(dec.port) < NPORTS;
    assign wr_ok   = wr_i && port_ok && writable(dec);

    gpio_sync2 #(.W(NPINS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (pad_in_i),
        .q_o (sync_w)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        localparam int LO = p * PORT_W;
        gpio_port #(.PW(PORT_W)) u_port (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (wr_ok && int'(dec.port) == p),
            .alias_sel (dec.alias_sel),
            .grp       (dec.grp),
            .wdata     (wdata_i[2*PORT_W-1:0]),
            .evt       (irq_evt_i[LO +: PORT_W]),
            .cfg       (cfg_p[p]),
            .oe        (oe_p[p]),
            .out       (out_p[p]),
            .sts       (sts_p[p]),
            .en        (en_p[p]),
            .typ       (typ_p[p])
        );
        assign cfg_o[LO +: PORT_W]      = cfg_p[p];
        assign oe_w[LO +: PORT_W]       = oe_p[p];
        assign out_w[LO +: PORT_W]      = out_p[p];
        assign sts_w[LO +: PORT_W]      = sts_p[p];
        assign int_en_o[LO +: PORT_W]   = en_p[p];
        assign int_type_o[LO +: PORT_W] = typ_p[p];
    end

    always_comb begin
        rd_val = '0;
        if (dec.in_bank && port_ok && !dec.alias_sel) begin
            case (dec.grp)
                GRP_CFG: rd_val[PORT_W-1:0] = cfg_p[dec.port];
                GRP_OE:  rd_val[PORT_W-1:0] = oe_p[dec.port];
                GRP_OUT: rd_val[PORT_W-1:0] = out_p[dec.port];
                GRP_IN:  rd_val[PORT_W-1:0] = sync_w[int'(dec.port)*PORT_W +: PORT_W];
                GRP_STS: rd_val[PORT_W-1:0] = sts_p[dec.port];
                GRP_EN:  rd_val[PORT_W-1:0] = en_p[dec.port];
                GRP_TYP: rd_val[PORT_W-1:0] = typ_p[dec.port];
                default: rd_val = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata_o <= '0;
        else if (rd_i)
            rdata_o <= rd_val;
    end

    assign pad_oe_o   = oe_w;
    assign pad_out_o  = out_w & oe_w;
    assign pin_sync_o = sync_w;
    assign irq_o      = |(sts_w & int_en_o);
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int PORT_W = 8
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     wr_i,
    input logic                     rd_i,
    input logic [ADDR_W-1:0]        addr_i,
    input logic [DATA_W-1:0]        wdata_i,
    input logic [DATA_W-1:0]        rdata_o,
    input logic [NPORTS*PORT_W-1:0] pad_in_i,
    input logic [NPORTS*PORT_W-1:0] pad_out_o,
    input logic [NPORTS*PORT_W-1:0] pad_oe_o,
    input logic [NPORTS*PORT_W-1:0] int_en_o,
    input logic [NPORTS*PORT_W-1:0] pin_sync_o,
    input logic [NPORTS*PORT_W-1:0] irq_evt_i,
    input logic                     irq_o
);
    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)
            since_rst <= '0;
        else if (since_rst != 2'd3)
            since_rst <= since_rst + 2'd1;
    end

    // R1: state left by reset
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pad_oe_o == '0 && irq_o == 1'b0 && rdata_o == '0));

    // R3: pads only move on a bus write
    p_hold_nowr_r3: assert property (@(posedge clk) disable iff (rst)
        !wr_i |=> ($stable(pad_oe_o) && $stable(pad_out_o)));

    // R4: a masked write with an empty mask changes no drive enable
    p_mask_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_i && addr_i[11] && addr_i[6:4] == 3'd1 && wdata_i[15:8] == 8'h00)
        |=> $stable(pad_oe_o));

    // R6: two-edge synchronizer latency
    p_sync_lat_r6: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2) |-> (pin_sync_o == $past(pad_in_i, 2)));

    // R7: an enabled event raises the bank interrupt
    p_evt_irq_r7: assert property (@(posedge clk) disable iff (rst)
        ((irq_evt_i & int_en_o) != '0 && !wr_i) |=> irq_o);

    // R9: the clear group reads as zero
    p_clr_read_zero_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(rd_i) && $past(addr_i[6:4]) == 3'd7) |-> (rdata_o == '0));
endmodule

bind gpio_bank gpio_bank_chk #(.NPORTS(NPORTS), .PORT_W(PORT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_i       (wr_i),
    .rd_i       (rd_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .pad_in_i   (pad_in_i),
    .pad_out_o  (pad_out_o),
    .pad_oe_o   (pad_oe_o),
    .int_en_o   (int_en_o),
    .pin_sync_o (pin_sync_o),
    .irq_evt_i  (irq_evt_i),
    .irq_o      (irq_o)
);

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_i = 1'b0;
    logic        rd_i = 1'b0;
    logic [11:0] addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic [31:0] pad_in_i = '0;
    logic [31:0] pad_out_o, pad_oe_o, cfg_o, int_en_o, int_type_o, pin_sync_o;
    logic [31:0] irq_evt_i = '0;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] rd;

    always #2.5 clk = ~clk;

    gpio_bank dut (
        .clk(clk), .rst(rst), .wr_i(wr_i), .rd_i(rd_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .pad_in_i(pad_in_i),
        .pad_out_o(pad_out_o), .pad_oe_o(pad_oe_o), .cfg_o(cfg_o),
        .int_en_o(int_en_o), .int_type_o(int_type_o), .pin_sync_o(pin_sync_o),
        .irq_evt_i(irq_evt_i), .irq_o(irq_o)
    );

    function automatic logic [11:0] ra(int grp, int port, bit al);
        return {al, 4'b0000, grp[2:0], port[1:0], 2'b00};
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        addr_i = a; wdata_i = d; wr_i = 1'b1;
        @(negedge clk);
        wr_i = 1'b0;
    endtask

    task automatic bus_rd(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        addr_i = a; rd_i = 1'b1;
        @(negedge clk);
        rd_i = 1'b0;
        d = rdata_o;
    endtask

    task automatic t_reset;
        chk("R1 pad_oe", pad_oe_o, 32'h0);
        chk("R1 pad_out", pad_out_o, 32'h0);
        chk("R1 irq", {31'h0, irq_o}, 32'h0);
        for (int g = 0; g < 7; g++) begin
            bus_rd(ra(g, 3, 1'b0), rd);
            chk("R1 reg zero", rd, 32'h0);
        end
    endtask

    task automatic t_plain;
        bus_wr(ra(0, 2, 1'b0), 32'h0000_00A5);
        bus_rd(ra(0, 2, 1'b0), rd);
        chk("R2 cfg readback", rd, 32'h0000_00A5);
        chk("R10 cfg_o", cfg_o, 32'h00A5_0000);
        bus_wr(ra(6, 1, 1'b0), 32'hFFFF_FF3C);
        bus_rd(ra(6, 1, 1'b0), rd);
        chk("R2 upper data ignored", rd, 32'h0000_003C);
        chk("R10 int_type_o", int_type_o, 32'h0000_3C00);
    endtask

    task automatic t_masked;
        bus_wr(ra(2, 0, 1'b0), 32'h0000_000F);
        bus_wr(ra(2, 0, 1'b1), 32'h0000_A0F0);
        bus_rd(ra(2, 0, 1'b0), rd);
        chk("R4 masked set", rd, 32'h0000_00AF);
        bus_wr(ra(2, 0, 1'b1), 32'h0000_0300);
        bus_rd(ra(2, 0, 1'b0), rd);
        chk("R4 masked clear", rd, 32'h0000_00AC);
        bus_wr(ra(2, 0, 1'b1), 32'h0000_00FF);
        bus_rd(ra(2, 0, 1'b0), rd);
        chk("R4 empty mask", rd, 32'h0000_00AC);
    endtask

    task automatic t_pads;
        chk("R5 released", pad_out_o, 32'h0);
        bus_wr(ra(1, 0, 1'b0), 32'h0000_000F);
        chk("R5 pad_oe", pad_oe_o, 32'h0000_000F);
        chk("R5 pad_out", pad_out_o, 32'h0000_000C);
        bus_wr(ra(1, 0, 1'b1), 32'h0000_8080);
        chk("R5 masked oe", pad_oe_o, 32'h0000_008F);
        chk("R5 pad_out after oe", pad_out_o, 32'h0000_008C);
        repeat (3) @(negedge clk);
        chk("R3 no write hold", pad_out_o, 32'h0000_008C);
    endtask

    task automatic t_input;
        @(negedge clk);
        pad_in_i = 32'h1234_5678;
        @(negedge clk);
        chk("R6 one edge old", pin_sync_o, 32'h0);
        @(negedge clk);
        chk("R6 two edges new", pin_sync_o, 32'h1234_5678);
        bus_rd(ra(3, 1, 1'b0), rd);
        chk("R6 input read", rd, 32'h0000_0056);
        bus_wr(ra(3, 1, 1'b0), 32'h0000_00FF);
        bus_rd(ra(3, 1, 1'b0), rd);
        chk("R6 input write ignored", rd, 32'h0000_0056);
    endtask

    task automatic t_irq;
        bus_wr(ra(5, 3, 1'b0), 32'h0000_0001);
        chk("R10 int_en_o", int_en_o, 32'h0100_0000);
        chk("R7 idle irq", {31'h0, irq_o}, 32'h0);
        @(negedge clk); irq_evt_i = 32'h0100_0000;
        @(negedge clk); irq_evt_i = 32'h0;
        chk("R7 irq raised", {31'h0, irq_o}, 32'h1);
        @(negedge clk); irq_evt_i = 32'h0200_0000;
        @(negedge clk); irq_evt_i = 32'h0;
        bus_rd(ra(4, 3, 1'b0), rd);
        chk("R7 status bits", rd, 32'h0000_0003);
        bus_wr(ra(7, 3, 1'b0), 32'h0000_0002);
        bus_rd(ra(4, 3, 1'b0), rd);
        chk("R8 clear one", rd, 32'h0000_0001);
        bus_wr(ra(7, 3, 1'b0), 32'h0000_0000);
        bus_rd(ra(4, 3, 1'b0), rd);
        chk("R8 zero no effect", rd, 32'h0000_0001);
        @(negedge clk);
        addr_i = ra(7, 3, 1'b0); wdata_i = 32'h1; wr_i = 1'b1;
        irq_evt_i = 32'h0100_0000;
        @(negedge clk);
        wr_i = 1'b0; irq_evt_i = 32'h0;
        bus_rd(ra(4, 3, 1'b0), rd);
        chk("R8 event wins", rd, 32'h0000_0001);
        bus_wr(ra(7, 3, 1'b0), 32'h0000_0001);
        chk("R7 irq dropped", {31'h0, irq_o}, 32'h0);
    endtask

    task automatic t_unmapped;
        bus_rd(ra(7, 3, 1'b0), rd);
        chk("R9 clear reads zero", rd, 32'h0);
        bus_rd(ra(2, 0, 1'b1), rd);
        chk("R9 alias reads zero", rd, 32'h0);
        bus_wr(12'h0A0, 32'h0000_FFFF);
        bus_rd(ra(2, 0, 1'b0), rd);
        chk("R9 stray bit write ignored", rd, 32'h0000_00AC);
        bus_rd(12'h0A0, rd);
        chk("R9 stray bit read zero", rd, 32'h0);
        @(negedge clk); irq_evt_i = 32'h0000_0001;
        @(negedge clk); irq_evt_i = 32'h0;
        bus_wr(ra(7, 0, 1'b1), 32'h0000_FFFF);
        bus_rd(ra(4, 0, 1'b0), rd);
        chk("R9 clear alias ignored", rd, 32'h0000_0001);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_plain();
        t_masked();
        t_pads();
        t_input();
        t_irq();
        t_unmapped();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule